// File: doc/BRIEF.md
# Grouped Interrupt Status Aggregator

This block folds a group of 32 level-type interrupt source lines into one interrupt output for a processor. Firmware programs a set of enable bits, which latch into a hidden sticky set that never loses a bit. The same enable register is reused during service to mask and unmask individual sources. An event is taken when the group's combined input rises. The enabled active lines form the selected set, which is either delivered into the status register (raising the output) or deferred into a hidden pending set.

Firmware acknowledges by writing ones to the status register. When an acknowledge empties the status register, deferred events are replayed into status and the output stays high. If nothing is deferred, the output drops. A status write of all ones clears the register and does nothing else. A simple word-wide register bus writes and reads back the enable and status registers.

The control is a two-state machine. GRP_QUIET means the output is low. GRP_SIGNALED means the output is high. The transition QUIET to SIGNALED happens on delivery or on replay. SIGNALED to QUIET happens when an acknowledge empties status with nothing pending and no delivery arrives in the same cycle. SIGNALED stays SIGNALED on a replay, on a partial acknowledge and on an all-ones clear. QUIET stays QUIET on a deferral or an empty acknowledge.

Top module: `grp_irq_aggregator`

## Requirements
- R1: Reset clears the stored enable value, the sticky enable set, the mask set, status and pending, and drives `irq_o` low.
- R2: An event is evaluated only in the cycle in which the OR of `src_i` goes from 0 to 1. Lines held high cause no further event, and deassertion does nothing. The selected set is `src_i` AND the sticky set, and an empty selected set changes nothing.
- R3: If the selected set overlaps the mask set or the current status, it is ORed into pending, and status and `irq_o` are unchanged.
- R4: Otherwise status is overwritten with the selected set, and `irq_o` is high from the next cycle.
- R5: An enable write of zero while the sticky set is zero stores zero and changes nothing else.
- R6: An enable write carrying bits absent from the sticky set ORs them into it and stores the written value, and the mask set is left unchanged.
- R7: An enable write adding no sticky bits computes d = stored XOR written. If d AND written is nonzero, the bits of d are removed from the mask; otherwise they are added. The written value is stored.
- R8: A status write of zero is ignored. Any other status write clears the written bits.
- R9: A status write of all ones clears status only: no replay and no change of `irq_o`.
- R10: A status write (not all ones) that leaves status zero copies a nonzero pending set into status, clears pending and holds `irq_o` high. With pending empty it drives `irq_o` low.
- R11: A bus write and an event in the same cycle: the write is applied first, and the event is evaluated against the updated enable, mask and status.
- R12: `rd_data_o` returns the stored enable value when `rd_sel_i`=0 and the status when `rd_sel_i`=1. All updates take effect on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt source levels |
| wr_en_i | input | 1 | Register write strobe, one word per cycle |
| wr_sel_i | input | 1 | Write target: 0 enable, 1 status |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read target: 0 enable, 1 status |
| rd_data_o | output | 32 | Read data, combinational from stored values |
| irq_o | output | 1 | Group interrupt output |

## Verification
The assertions assume the following about the inputs:
- Source levels and bus strobes are synchronous to `clk` and stable around the rising edge.
- At most one register is written per cycle.
- Reset is held for at least one edge.

The stimulus drives every input on the falling edge and issues single-cycle writes. Between events it returns all source lines to zero, so that each new pattern forms a fresh rise of the combined input. The only exceptions are the deliberate hold test and the same-cycle write/event test.

// File: rtl/gia_pkg.sv
package gia_pkg;
    typedef enum logic {
        GRP_QUIET    = 1'b0,
        GRP_SIGNALED = 1'b1
    } grp_state_e;

    typedef enum logic {
        REG_ENABLE = 1'b0,
        REG_STATUS = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/gia_src_detect.sv
module gia_src_detect #(
    parameter int SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    output logic             fire_o
);
    logic any_now;
    logic any_prev_q;

    assign any_now = |src_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) any_prev_q <= 1'b0;
        else        any_prev_q <= any_now;
    end

    assign fire_o = any_now && !any_prev_q;

    // R2
    fire_not_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
endmodule

// File: rtl/gia_enable_ctl.sv
module gia_enable_ctl #(
    parameter int SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [SRC_W-1:0] wdata_i,
    output logic [SRC_W-1:0] en_o,
    output logic [SRC_W-1:0] sticky_nxt_o,
    output logic [SRC_W-1:0] mask_nxt_o
);
    logic [SRC_W-1:0] en_q, sticky_q, mask_q;
    logic [SRC_W-1:0] en_n, sticky_n, mask_n;
    logic [SRC_W-1:0] diff;
    logic             adds_bits;

    assign diff      = en_q ^ wdata_i;
    assign adds_bits = (wdata_i & ~sticky_q) != '0;

    always_comb begin
        en_n     = en_q;
        sticky_n = sticky_q;
        mask_n   = mask_q;
        if (wr_i) begin
            if (wdata_i == '0 && sticky_q == '0) begin
                en_n = '0;
            end else if (adds_bits) begin
                sticky_n = sticky_q | wdata_i;
                en_n     = wdata_i;
            end else begin
                if ((diff & wdata_i) != '0) mask_n = mask_q & ~diff;
                else                        mask_n = mask_q | diff;
                en_n = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            sticky_q <= '0;
            mask_q   <= '0;
        end else begin
            en_q     <= en_n;
            sticky_q <= sticky_n;
            mask_q   <= mask_n;
        end
    end

    assign en_o         = en_q;
    assign sticky_nxt_o = sticky_n;
    assign mask_nxt_o   = mask_n;

    // R6
    sticky_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

    // R6
    grow_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && adds_bits) |=> $stable(mask_q));
endmodule

// File: rtl/gia_status_core.sv
module gia_status_core
    import gia_pkg::*;
#(
    parameter int SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_wr_i,
    input  logic [SRC_W-1:0] wdata_i,
    input  logic             fire_i,
    input  logic [SRC_W-1:0] src_i,
    input  logic [SRC_W-1:0] sticky_i,
    input  logic [SRC_W-1:0] mask_i,
    output logic [SRC_W-1:0] status_o,
    output logic             irq_o
);
    localparam logic [SRC_W-1:0] ALL_ONES = '1;

    grp_state_e       state_q, state_n;
    logic [SRC_W-1:0] status_q, pend_q;
    logic [SRC_W-1:0] s_ack, p_ack, s_n, p_n, sel;
    logic             ack_empty, replay, hit, overlap, deliver;

    // write side first
    always_comb begin
        s_ack     = status_q;
        p_ack     = pend_q;
        ack_empty = 1'b0;
        replay    = 1'b0;
        if (st_wr_i && wdata_i != '0) begin
            s_ack = status_q & ~wdata_i;
            if (wdata_i != ALL_ONES && s_ack == '0) begin
                if (pend_q != '0) begin
                    s_ack  = pend_q;
                    p_ack  = '0;
                    replay = 1'b1;
                end else begin
                    ack_empty = 1'b1;
                end
            end
        end
    end

    // then the event against the updated state
    assign sel     = src_i & sticky_i;
    assign hit     = fire_i && (sel != '0);
    assign overlap = (sel & (mask_i | s_ack)) != '0;
    assign deliver = hit && !overlap;

    always_comb begin
        s_n = s_ack;
        p_n = p_ack;
        if (hit) begin
            if (overlap) p_n = p_ack | sel;
            else         s_n = sel;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            GRP_QUIET:    if (deliver || replay) state_n = GRP_SIGNALED;
            GRP_SIGNALED: if (ack_empty && !deliver) state_n = GRP_QUIET;
            default:      state_n = GRP_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= GRP_QUIET;
            status_q <= '0;
            pend_q   <= '0;
        end else begin
            state_q  <= state_n;
            status_q <= s_n;
            pend_q   <= p_n;
        end
    end

    always_comb begin
        irq_o    = (state_q == GRP_SIGNALED);
        status_o = status_q;
    end

    // R8
    zero_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_i && wdata_i == '0 && !fire_i) |=> $stable(status_o));

    // R9
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_i && wdata_i == ALL_ONES && !fire_i) |=> (status_o == '0 && $stable(irq_o)));

    // R10
    drop_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> (status_o == '0));

    // R3
    defer_holds_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && !st_wr_i && (((src_i & sticky_i) & (mask_i | status_o)) != '0))
            |=> ($stable(irq_o) && $stable(status_o)));
endmodule

// File: rtl/grp_irq_aggregator.sv
module grp_irq_aggregator
    import gia_pkg::*;
#(
    parameter int SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [SRC_W-1:0] wr_data_i,
    input  logic             rd_sel_i,
    output logic [SRC_W-1:0] rd_data_o,
    output logic             irq_o
);
    reg_sel_e         wsel, rsel;
    logic             en_wr, st_wr, fire;
    logic [SRC_W-1:0] en_val, sticky_nxt, mask_nxt, status_val;

    assign wsel  = reg_sel_e'(wr_sel_i);
    assign rsel  = reg_sel_e'(rd_sel_i);
    assign en_wr = wr_en_i && (wsel == REG_ENABLE);
    assign st_wr = wr_en_i && (wsel == REG_STATUS);

    gia_src_detect #(.SRC_W(SRC_W)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .fire_o (fire)
    );

    gia_enable_ctl #(.SRC_W(SRC_W)) u_enable (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (en_wr),
        .wdata_i      (wr_data_i),
        .en_o         (en_val),
        .sticky_nxt_o (sticky_nxt),
        .mask_nxt_o   (mask_nxt)
    );

    gia_status_core #(.SRC_W(SRC_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_wr_i  (st_wr),
        .wdata_i  (wr_data_i),
        .fire_i   (fire),
        .src_i    (src_i),
        .sticky_i (sticky_nxt),
        .mask_i   (mask_nxt),
        .status_o (status_val),
        .irq_o    (irq_o)
    );

    always_comb begin
        unique case (rsel)
            REG_ENABLE: rd_data_o = en_val;
            REG_STATUS: rd_data_o = status_val;
            default:    rd_data_o = '0;
        endcase
    end

    // R4
    status_means_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_val != '0) |-> irq_o);
endmodule

// File: tb/tb_grp_irq_aggregator.sv
`timescale 1ns/1ps
module tb_grp_irq_aggregator;
    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  op;     // 0 idle, 1 enable write, 2 status write, 3 source pulse
        logic [31:0] data;
        logic [31:0] en;
        logic [31:0] st;
        logic        irq;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{4'd5,  2'd1, 32'h0,        32'h0,  32'h0,  1'b0}, // R5
        '{4'd2,  2'd3, 32'h1,        32'h0,  32'h0,  1'b0}, // R2 nothing enabled
        '{4'd6,  2'd1, 32'hF,        32'hF,  32'h0,  1'b0}, // R6
        '{4'd4,  2'd3, 32'h11,       32'hF,  32'h1,  1'b1}, // R4
        '{4'd4,  2'd3, 32'h2,        32'hF,  32'h2,  1'b1}, // R4 disjoint overwrites
        '{4'd3,  2'd3, 32'h2,        32'hF,  32'h2,  1'b1}, // R3 defer
        '{4'd4,  2'd3, 32'h4,        32'hF,  32'h4,  1'b1}, // R4
        '{4'd10, 2'd2, 32'h4,        32'hF,  32'h2,  1'b1}, // R10 replay
        '{4'd10, 2'd2, 32'h2,        32'hF,  32'h0,  1'b0}, // R10 drop
        '{4'd4,  2'd3, 32'h1,        32'hF,  32'h1,  1'b1}, // R4
        '{4'd8,  2'd2, 32'h0,        32'hF,  32'h1,  1'b1}, // R8 zero ignored
        '{4'd9,  2'd2, 32'hFFFFFFFF, 32'hF,  32'h0,  1'b1}, // R9
        '{4'd4,  2'd3, 32'h1,        32'hF,  32'h1,  1'b1}, // R4
        '{4'd10, 2'd2, 32'h1,        32'hF,  32'h0,  1'b0}, // R10
        '{4'd7,  2'd1, 32'hE,        32'hE,  32'h0,  1'b0}, // R7 mask bit0
        '{4'd7,  2'd3, 32'h1,        32'hE,  32'h0,  1'b0}, // R7 masked -> pending
        '{4'd7,  2'd1, 32'hF,        32'hF,  32'h0,  1'b0}, // R7 unmask bit0
        '{4'd10, 2'd2, 32'h8,        32'hF,  32'h1,  1'b1}, // R10 replay from empty status
        '{4'd8,  2'd2, 32'h1,        32'hF,  32'h0,  1'b0}, // R8
        '{4'd6,  2'd1, 32'h30,       32'h30, 32'h0,  1'b0}, // R6
        '{4'd4,  2'd3, 32'h20,       32'h30, 32'h20, 1'b1}, // R4
        '{4'd7,  2'd1, 32'h0,        32'h0,  32'h20, 1'b1}, // R7 zero write masks 0x30
        '{4'd10, 2'd2, 32'h20,       32'h0,  32'h0,  1'b0}, // R10
        '{4'd3,  2'd3, 32'h10,       32'h0,  32'h0,  1'b0}, // R3 masked
        '{4'd2,  2'd3, 32'h40,       32'h0,  32'h0,  1'b0}, // R2 not sticky
        '{4'd9,  2'd2, 32'hFFFFFFFF, 32'h0,  32'h0,  1'b0}, // R9 no replay
        '{4'd10, 2'd2, 32'h1,        32'h0,  32'h10, 1'b1}, // R10 replay
        '{4'd12, 2'd2, 32'h10,       32'h0,  32'h0,  1'b0}  // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        wr_en_i = 1'b0;
    logic        wr_sel_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        rd_sel_i = 1'b0;
    logic [31:0] rd_data_o;
    logic        irq_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    grp_irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmp(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // R12 read-back path used by every check
    task automatic check_state(input int req, input logic [31:0] en, input logic [31:0] st, input logic irq);
        rd_sel_i = 1'b0; #0.5;
        cmp(req, "enable", rd_data_o, en);
        rd_sel_i = 1'b1; #0.5;
        cmp(req, "status", rd_data_o, st);
        cmp(req, "irq", {31'b0, irq_o}, {31'b0, irq});
    endtask

    task automatic apply(input vec_t v);
        wr_en_i = (v.op == 2'd1) || (v.op == 2'd2);
        wr_sel_i = (v.op == 2'd2);
        wr_data_i = v.data;
        src_i = (v.op == 2'd3) ? v.data : '0;
        tick();
        wr_en_i = 1'b0;
        src_i = '0;
        check_state(int'(v.req), v.en, v.st, v.irq);
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        tick();
        // R1 reset state
        check_state(1, 32'h0, 32'h0, 1'b0);
        rst_n = 1'b1;
        tick();
        check_state(1, 32'h0, 32'h0, 1'b0);

        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // R11 setup: deliver 0x4 then acknowledge
        apply('{4'd11, 2'd3, 32'h4, 32'h0, 32'h4, 1'b1});
        apply('{4'd11, 2'd2, 32'h4, 32'h0, 32'h0, 1'b0});
        // R11 unmask write and event on the same edge: write wins first
        wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 32'h10; src_i = 32'h10;
        tick();
        wr_en_i = 1'b0; src_i = '0;
        check_state(11, 32'h10, 32'h10, 1'b1);
        tick();

        // R1 reset mid-run clears all state including sticky set
        rst_n = 1'b0;
        tick();
        check_state(1, 32'h0, 32'h0, 1'b0);
        rst_n = 1'b1;
        tick();
        apply('{4'd1, 2'd3, 32'h1, 32'h0, 32'h0, 1'b0});
        apply('{4'd6, 2'd1, 32'h1, 32'h1, 32'h0, 1'b0});

        // R2 held source: one event only
        src_i = 32'h1;
        tick();
        check_state(2, 32'h1, 32'h1, 1'b1);
        wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = 32'h1;
        tick();
        wr_en_i = 1'b0;
        check_state(2, 32'h1, 32'h0, 1'b0);
        tick();
        check_state(2, 32'h1, 32'h0, 1'b0);
        src_i = '0;
        tick();
        check_state(2, 32'h1, 32'h0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule